// File: doc/BRIEF.md
# Integer ALU with Compare and Shift

A purely combinational integer arithmetic and logic unit for a small load/store RISC datapath. It takes two operand words, a shift distance and a 4-bit operation code. It returns one result word and a flag that is high when that result is all zeros. The execute stage uses the flag to resolve equal and not-equal branches, by subtracting the two registers and testing the flag.

The unit covers the following operations:
- wrap-around add and subtract;
- AND, OR and NOR;
- logical left and right shifts, and an arithmetic right shift;
- signed and unsigned less-than compares that yield 0 or 1;
- an upper-half constant load that moves the low half of operand B into the high half of the result.

Codes outside the defined set yield zero. There are no registers, so every result follows its inputs in the same cycle. The unit has no handshake, because a datapath stage samples its outputs with its own pipeline register.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives a_i + b_i modulo 2^32.
- R2: Code 1 (subtract) gives a_i - b_i modulo 2^32.
- R3: Code 2 gives a_i AND b_i; code 3 gives a_i OR b_i.
- R4: Code 4 (NOR) gives the bitwise inverse of (a_i OR b_i).
- R5: Code 5 shifts a_i left by shamt_i (0 to 31) and fills the vacated low bits with zeros.
- R6: Code 6 shifts a_i right by shamt_i and fills the vacated high bits with zeros.
- R7: Code 7 shifts a_i right by shamt_i and fills the vacated high bits with copies of a_i[31]. A distance of 0 returns a_i unchanged.
- R8: Code 8 gives 1 when a_i < b_i as two's-complement numbers and 0 otherwise. The answer stays correct when a_i - b_i overflows.
- R9: Code 9 gives 1 when a_i < b_i as unsigned numbers and 0 otherwise.
- R10: Code 10 gives {b_i[15:0], 16'h0000} and ignores a_i.
- R11: Codes 11 to 15 give a result of 0.
- R12: zero_o is 1 exactly when result_o is all zeros. For example, subtracting equal operands raises it.
- R13: Outputs are combinational and valid in the same cycle as the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, and the value shifted by shift codes |
| b_i | input | 32 | Second operand; its low half is the constant for code 10 |
| shamt_i | input | 5 | Shift distance |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
Every result of this unit is due zero cycles after its stimulus, since no register lies between any input and either output. The bench changes inputs on the falling clock edge and samples result_o and zero_o two nanoseconds later, once the combinational paths have settled and well before the next rising edge. Each vector therefore checks the result of its own inputs only. Corner vectors cover overflowing signed compares, shifts by 0 and 31, wrap-around add, and every undefined code class.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_LUI  = 4'd10
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    // two's-complement overflow: same-sign inputs, different-sign sum
    ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] stg [0:SHW];
  logic             fill;
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;

  // left shifts reuse the right shifter on bit-reversed data
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      rev_in[i] = data_i[MSB-i];
    end
    fill    = arith_i & ~left_i & data_i[MSB];
    stg[0]  = left_i ? rev_in : data_i;
  end

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    always_comb begin
      if (amt_i[k]) stg[k+1] = {{D{fill}}, stg[k][MSB:D]};
      else          stg[k+1] = stg[k];
    end
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      rev_out[i] = stg[SHW][MSB-i];
    end
    data_o = left_i ? rev_out : stg[SHW];
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    nor_o = ~(a_i | b_i);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH),
  parameter int OPW   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [OPW-1:0]   op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  localparam int MSB  = WIDTH - 1;
  localparam int HALF = WIDTH / 2;

  logic             use_sub;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             ovf;
  logic [WIDTH-1:0] w_and, w_or, w_nor;
  logic [WIDTH-1:0] shifted;
  logic             sh_left, sh_arith;
  logic             less_s, less_u;

  always_comb begin
    use_sub  = (op_i == OP_SUB) || (op_i == OP_SLT) || (op_i == OP_SLTU);
    sh_left  = (op_i == OP_SLL);
    sh_arith = (op_i == OP_SRA);
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(use_sub),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i(a_i), .b_i(b_i), .and_o(w_and), .or_o(w_or), .nor_o(w_nor)
  );

  alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .data_i(a_i), .amt_i(shamt_i), .left_i(sh_left),
    .arith_i(sh_arith), .data_o(shifted)
  );

  always_comb begin
    // signed less-than survives overflow; unsigned uses the borrow
    less_s = sum[MSB] ^ ovf;
    less_u = ~carry;
    unique case (op_i)
      OP_ADD, OP_SUB:          result_o = sum;
      OP_AND:                  result_o = w_and;
      OP_OR:                   result_o = w_or;
      OP_NOR:                  result_o = w_nor;
      OP_SLL, OP_SRL, OP_SRA:  result_o = shifted;
      OP_SLT:                  result_o = {{(WIDTH-1){1'b0}}, less_s};
      OP_SLTU:                 result_o = {{(WIDTH-1){1'b0}}, less_u};
      OP_LUI:                  result_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      default:                 result_o = '0;
    endcase
    zero_o = (result_o == '0);
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH),
  parameter int OPW   = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [OPW-1:0]   op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    if (zero_o) begin
      p_zero_means_empty_r12: assert (result_o == '0);
    end
    if (op_i == OP_SLT) begin
      p_slt_is_bool_r8: assert (result_o[WIDTH-1:1] == '0);
    end
    if (op_i == OP_SLTU) begin
      p_sltu_is_bool_r9: assert (result_o[WIDTH-1:1] == '0);
    end
    if (op_i == OP_LUI) begin
      p_lui_low_clear_r10: assert (result_o[HALF-1:0] == '0);
    end
    if (op_i > OPW'(OP_LUI)) begin
      p_undef_zero_r11: assert (result_o == '0 && zero_o);
    end
    if (op_i == OP_SLL && shamt_i != '0) begin
      p_sll_lsb_clear_r5: assert (result_o[0] == 1'b0);
    end
    if (op_i == OP_SRL && shamt_i != '0) begin
      p_srl_msb_clear_r6: assert (result_o[WIDTH-1] == 1'b0);
    end
    if (op_i == OP_SRA) begin
      p_sra_sign_kept_r7: assert (result_o[WIDTH-1] == a_i[WIDTH-1]);
    end
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .SHW(SHW), .OPW(OPW)) chk_i (
  .a_i(a_i), .shamt_i(shamt_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o)
);

// File: tb/alu_core_tb_top.sv
`timescale 1ns/1ps
module alu_core_tb_top;
  localparam int NV = 28;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'd6,          32'd3,          5'd0,  32'd9,          4'd1},  // R1
    '{4'd0,  32'hFFFFFFFF,   32'd1,          5'd0,  32'd0,          4'd1},  // R1 wrap, R12
    '{4'd1,  32'd5,          32'd7,          5'd0,  32'hFFFFFFFE,   4'd2},  // R2
    '{4'd1,  32'd1234,       32'd1234,       5'd0,  32'd0,          4'd12}, // R12 equal
    '{4'd2,  32'd8,          32'd14,         5'd0,  32'd8,          4'd3},  // R3
    '{4'd3,  32'd8,          32'd14,         5'd0,  32'd14,         4'd3},  // R3
    '{4'd4,  32'd0,          32'd0,          5'd0,  32'hFFFFFFFF,   4'd4},  // R4
    '{4'd4,  32'hF0F0F0F0,   32'h0F0F0F00,   5'd0,  32'h0000000F,   4'd4},  // R4
    '{4'd5,  32'd1,          32'd0,          5'd31, 32'h80000000,   4'd5},  // R5
    '{4'd5,  32'h12345678,   32'd0,          5'd4,  32'h23456780,   4'd5},  // R5
    '{4'd6,  32'h80000000,   32'd0,          5'd31, 32'd1,          4'd6},  // R6
    '{4'd6,  32'hF0000000,   32'd0,          5'd4,  32'h0F000000,   4'd6},  // R6
    '{4'd7,  32'hF0000000,   32'd0,          5'd4,  32'hFF000000,   4'd7},  // R7
    '{4'd7,  32'h70000000,   32'd0,          5'd4,  32'h07000000,   4'd7},  // R7
    '{4'd7,  32'h80000000,   32'd0,          5'd31, 32'hFFFFFFFF,   4'd7},  // R7
    '{4'd7,  32'h80000001,   32'd0,          5'd0,  32'h80000001,   4'd7},  // R7 zero dist
    '{4'd8,  32'hFFFFFFFC,   32'd2,          5'd0,  32'd1,          4'd8},  // R8
    '{4'd8,  32'd2,          32'hFFFFFFFC,   5'd0,  32'd0,          4'd8},  // R8
    '{4'd8,  32'h80000000,   32'd1,          5'd0,  32'd1,          4'd8},  // R8 overflow
    '{4'd8,  32'h7FFFFFFF,   32'hFFFFFFFF,   5'd0,  32'd0,          4'd8},  // R8 overflow
    '{4'd9,  32'd1,          32'hFFFFFFFF,   5'd0,  32'd1,          4'd9},  // R9
    '{4'd9,  32'hFFFFFFFF,   32'd1,          5'd0,  32'd0,          4'd9},  // R9
    '{4'd9,  32'd77,         32'd77,         5'd0,  32'd0,          4'd9},  // R9 equal
    '{4'd10, 32'd0,          32'h1234ABCD,   5'd0,  32'hABCD0000,   4'd10}, // R10
    '{4'd10, 32'hFFFFFFFF,   32'h0000AAAA,   5'd0,  32'hAAAA0000,   4'd10}, // R10 a ignored
    '{4'd11, 32'd5,          32'd3,          5'd3,  32'd0,          4'd11}, // R11
    '{4'd15, 32'hFFFFFFFF,   32'hFFFFFFFF,   5'd7,  32'd0,          4'd11}, // R11
    '{4'd13, 32'h00000001,   32'h00000000,   5'd1,  32'd0,          4'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  alu_core dut_i (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .zero_o(zf)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [4:0] s);
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #2;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a = '0; b = '0; sh = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // reset-time state: all-zero inputs, add gives zero, R13 same cycle
    apply(4'd0, 32'd0, 32'd0, 5'd0);
    check("R13 idle result", res, 32'd0);
    check("R12 idle zero", {31'd0, zf}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh);
      check($sformatf("R%0d vec%0d result", VECS[i].req, i), res, VECS[i].exp);
      check($sformatf("R12 vec%0d zero", i), {31'd0, zf},
            {31'd0, (VECS[i].exp == 32'd0)});
    end

    // directed: every shift distance on one pattern (R5, R6, R7)
    for (int s = 0; s < 32; s++) begin
      apply(4'd5, 32'h8000_0001, 32'd0, 5'(s));
      check("R5 sweep", res, 32'h8000_0001 << s);
      apply(4'd6, 32'h8000_0001, 32'd0, 5'(s));
      check("R6 sweep", res, 32'h8000_0001 >> s);
      apply(4'd7, 32'h8000_0001, 32'd0, 5'(s));
      check("R7 sweep", res, 32'($signed(32'h8000_0001) >>> s));
    end

    // R13: output follows a change in the same cycle, no stale value
    apply(4'd0, 32'd100, 32'd23, 5'd0);
    check("R13 first", res, 32'd123);
    op = 4'd1;
    #1;
    check("R13 follow", res, 32'd77);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule